// File: doc/BRIEF.md
# Pulse Accumulator

This block is a 16-bit pulse accumulator intended to sit inside a timer peripheral. It watches a single external input and counts in one of two ways. In event mode, each transition of a chosen polarity on the input adds one to the counter. In gated mode, the counter advances once every 64 module clocks, but only while the input is held at its active level. Gated mode is therefore a way to measure how long the input stays active.

Software reaches the block through a small synchronous register port. Through it, software can program the mode and interrupt enables, load and read the count one byte at a time, and inspect or acknowledge two flags. The input flag marks input activity. The overflow flag marks that the counter wrapped. Each flag drives its own interrupt request output through its own enable. A timer-enable input from the surrounding timer starts and stops the divide-by-64 time base. Event counting does not depend on it.

Top module: `pulse_accum`

## Requirements
- R1: After reset the counter reads 0x0000. The control register reads 0x00, the flag register reads 0x00, and both interrupt outputs are low.
- R2: Register addresses are as follows. Address 0 is control, with bit0 = gated mode, bit1 = polarity select, bit2 = input interrupt enable and bit3 = overflow interrupt enable; its upper bits read 0. Address 1 holds the flags, with bit0 = input flag and bit1 = overflow flag. Address 2 is the counter high byte and address 3 is the counter low byte. Control and both counter bytes read back what was written.
- R3: In event mode with polarity select 0, each rising edge of the input adds exactly one to the counter, and falling edges add nothing. The input must hold each level for at least 3 clocks.
- R4: In event mode with polarity select 1, each falling edge adds exactly one, and rising edges add nothing.
- R5: Event-mode counting works the same whether timer-enable is high or low.
- R6: In gated mode with timer-enable high, the counter adds one every 64 clocks while the input is at its active level, and holds while the input is inactive. The active level is high when polarity select is 0 and low when it is 1. The first increment lands 64 clocks after timer-enable goes high.
- R7: In gated mode with timer-enable low, the counter does not change.
- R8: The input flag is set by a counted edge in event mode. In gated mode it is set by the edge that ends the active level, and not by the edge that starts it. The input interrupt output is high exactly when the input flag and its enable are both 1.
- R9: A wrap of the counter from 0xFFFF to 0x0000 sets the overflow flag, and a step to 0xFFFF does not. The overflow interrupt output is high exactly when the overflow flag and its enable are both 1.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a set condition and a clear land in the same cycle, the flag ends up set.
- R11: A write to a counter byte in the same cycle as an increment loads the written byte, and the increment is dropped. The other byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| pin_in | input | 1 | External accumulator input, asynchronous |
| timer_en | input | 1 | Timer enable; runs the divide-by-64 time base |
| irq_edge | output | 1 | Input-flag interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench aims at the cycle where an input edge and a register write meet. If a clear beat the input flag, or an increment beat a counter load, the flag would read 0 or the low byte would read 0x56 instead of 0x55. It checks that 0xFFFE to 0xFFFF leaves the overflow flag clear while the next wrap sets it. It also checks that clearing one flag leaves the other untouched. In gated mode it counts exact multiples of 64 clocks from timer-enable, so a prescaler off by one, or one that free-runs while disabled, gives the wrong count. It also checks that the gate-opening edge does not raise the input flag, which would catch a design that flags every edge in gated mode.

// File: rtl/pa_pkg.sv
// Shared definitions for the pulse accumulator: register addresses and
// the control register layout. Assumes a 2-bit register address space.
package pa_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_FLAG = 2'd1;
    localparam logic [1:0] ADDR_CNTH = 2'd2;
    localparam logic [1:0] ADDR_CNTL = 2'd3;

    localparam int FLAG_EDGE_BIT = 0;
    localparam int FLAG_OVF_BIT  = 1;

    // Control register, bit0 is the least significant member (gated).
    typedef struct packed {
        logic ovf_ien;
        logic edge_ien;
        logic pol_sel;
        logic gated;
    } pa_ctrl_t;

    localparam int CTRL_W = $bits(pa_ctrl_t);

endpackage

// File: rtl/pa_pin_sync.sv
// Brings the asynchronous accumulator input into the clock domain through
// a chain of STAGES flops, then compares the synchronised sample with the
// one from the previous cycle to produce single-cycle edge strobes.
// Assumes STAGES >= 2 and input levels held for more than STAGES clocks.
module pa_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    // Remember the last synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Decode level and edges from the current and previous sample.
    always_comb begin
        level = chain_q[STAGES-1];
        rise  = level & ~prev_q;
        fall  = ~level & prev_q;
    end

endmodule

// File: rtl/pa_prescale.sv
// Divide-by-DIV time base for gated accumulation. The divider is held at
// zero while disabled, so the first tick comes DIV clocks after enable.
// Assumes DIV >= 2.
module pa_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);

    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Flag the last state of the divide cycle while running.
    always_comb tick = enable && (div_q == LAST);

    // Advance the divider while enabled; hold it cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) div_q <= '0;
        else if (tick)         div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pa_count.sv
// Accumulator counter with byte-wide load ports. A load of either half has
// priority over an increment in the same cycle. wrap pulses when an
// increment takes the counter from all-ones to zero. Assumes W is even.
module pa_count #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_hi,
    input  logic           load_lo,
    input  logic [W/2-1:0] load_data,
    input  logic           inc,
    output logic [W-1:0]   count,
    output logic           wrap
);

    localparam int HW = W / 2;

    logic [W-1:0] cnt_q;
    logic         any_load;

    // Detect a load and a rollover caused by an unopposed increment.
    always_comb begin
        any_load = load_hi | load_lo;
        wrap     = inc && !any_load && (cnt_q == {W{1'b1}});
        count    = cnt_q;
    end

    // Update the counter: loads first, increment otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_load) begin
            if (load_hi) cnt_q[W-1:HW] <= load_data;
            if (load_lo) cnt_q[HW-1:0] <= load_data;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pulse_accum.sv
// Pulse accumulator top. Holds the control register and the two sticky
// flags, selects between edge counting and gated time counting, and
// decodes the register port. Assumes CNT_W is even and its half is at
// least CTRL_W bits wide, since the register port is half the counter.
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_DIV     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [CNT_W/2-1:0] reg_wdata,
    output logic [CNT_W/2-1:0] reg_rdata,
    input  logic               pin_in,
    input  logic               timer_en,
    output logic               irq_edge,
    output logic               irq_ovf
);

    localparam int DW = CNT_W / 2;

    pa_ctrl_t         ctrl_q;
    logic             flag_edge_q;
    logic             flag_ovf_q;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             pin_lvl;
    logic             pin_rise;
    logic             pin_fall;
    logic             tick;

    logic             wr_ctrl;
    logic             wr_flag;
    logic             wr_hi;
    logic             wr_lo;
    logic             act_edge;
    logic             gate_open;
    logic             gate_close;
    logic             cnt_inc;
    logic             edge_set;

    // Register write decode.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
        wr_hi   = reg_wr && (reg_addr == ADDR_CNTH);
        wr_lo   = reg_wr && (reg_addr == ADDR_CNTL);
    end

    pa_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .level     (pin_lvl),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    pa_prescale #(
        .DIV (PRE_DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (timer_en),
        .tick   (tick)
    );

    // Pick the counted edge, gate level and gate-ending edge by polarity.
    always_comb begin
        act_edge   = ctrl_q.pol_sel ? pin_fall : pin_rise;
        gate_open  = ctrl_q.pol_sel ? ~pin_lvl : pin_lvl;
        gate_close = ctrl_q.pol_sel ? pin_rise : pin_fall;
        cnt_inc    = ctrl_q.gated ? (tick & gate_open) : act_edge;
        edge_set   = ctrl_q.gated ? gate_close : act_edge;
    end

    pa_count #(
        .W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hi   (wr_hi),
        .load_lo   (wr_lo),
        .load_data (reg_wdata),
        .inc       (cnt_inc),
        .count     (count),
        .wrap      (wrap)
    );

    // Control register, loaded from the low bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= pa_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Sticky flags: a set condition wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_edge_q <= 1'b0;
            flag_ovf_q  <= 1'b0;
        end else begin
            flag_edge_q <= edge_set |
                           (flag_edge_q & ~(wr_flag & reg_wdata[FLAG_EDGE_BIT]));
            flag_ovf_q  <= wrap |
                           (flag_ovf_q & ~(wr_flag & reg_wdata[FLAG_OVF_BIT]));
        end
    end

    // Interrupt requests gated by their enables.
    always_comb begin
        irq_edge = flag_edge_q & ctrl_q.edge_ien;
        irq_ovf  = flag_ovf_q & ctrl_q.ovf_ien;
    end

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            ADDR_FLAG: reg_rdata = {{(DW-2){1'b0}}, flag_ovf_q, flag_edge_q};
            ADDR_CNTH: reg_rdata = count[CNT_W-1:DW];
            default:   reg_rdata = count[DW-1:0];
        endcase
    end

endmodule

// File: rtl/pa_accum_chk.sv
// Property checker for pulse_accum, bound to every instance of the top.
module pa_accum_chk
    import pa_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [CNT_W/2-1:0] reg_wdata,
    input logic               timer_en,
    input logic               gated,
    input logic [CNT_W-1:0]   count,
    input logic               flag_edge,
    input logic               flag_ovf
);

    logic cnt_wr;
    logic flag_wr;

    always_comb begin
        cnt_wr  = reg_wr && ((reg_addr == ADDR_CNTH) || (reg_addr == ADDR_CNTL));
        flag_wr = reg_wr && (reg_addr == ADDR_FLAG);
    end

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> ($past(count) == {CNT_W{1'b1}}));

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && !timer_en && !cnt_wr) |=> (count == $past(count)));

    // R10
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_edge) |-> $past(flag_wr && reg_wdata[FLAG_EDGE_BIT]));

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_ovf) |-> $past(flag_wr && reg_wdata[FLAG_OVF_BIT]));

endmodule

bind pulse_accum pa_accum_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .timer_en  (timer_en),
    .gated     (ctrl_q.gated),
    .count     (count),
    .flag_edge (flag_edge_q),
    .flag_ovf  (flag_ovf_q)
);

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pin_in = 1'b0;
    logic       timer_en = 1'b0;
    logic       irq_edge;
    logic       irq_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pulse_accum u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .timer_en  (timer_en),
        .irq_edge  (irq_edge),
        .irq_ovf   (irq_ovf)
    );

    // {is_read, addr[1:0], data[7:0], expect[7:0]}
    localparam int NV = 11;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h0F, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h0F},
        {1'b0, 2'd0, 8'hF5, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h05},
        {1'b0, 2'd0, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h00},
        {1'b0, 2'd2, 8'hA5, 8'h00},
        {1'b0, 2'd3, 8'h3C, 8'h00},
        {1'b1, 2'd2, 8'h00, 8'hA5},
        {1'b1, 2'd3, 8'h00, 8'h3C},
        {1'b1, 2'd1, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives a write for one clock.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(2'd2, h);
        rd(2'd3, l);
        c = {h, l};
    endtask

    task automatic set_cnt(input logic [15:0] c);
        wr(2'd2, c[15:8]);
        wr(2'd3, c[7:0]);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic lvl);
        pin_in = lvl;  hold(4);
        pin_in = ~lvl; hold(4);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] c;
        hold(3);
        rst_n = 1'b1;
        hold(1);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", {8'h0, d}, 16'h0);
        rd(2'd1, d); chk("R1 flags", {8'h0, d}, 16'h0);
        rd_cnt(c);   chk("R1 count", c, 16'h0);
        chk("R1 irqs", {14'h0, irq_edge, irq_ovf}, 16'h0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) begin
                rd(VEC[i][17:16], d);
                chk("R2 readback", {8'h0, d}, {8'h0, VEC[i][7:0]});
            end else begin
                wr(VEC[i][17:16], VEC[i][15:8]);
            end
        end

        // R3 R5: rising edges, timer disabled
        wr(2'd0, 8'h04);
        set_cnt(16'h0000);
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        rd_cnt(c); chk("R3 R5 rising count", c, 16'd3);
        rd(2'd1, d); chk("R8 edge flag", {8'h0, d}, 16'h01);
        chk("R8 irq_edge", {15'h0, irq_edge}, 16'h1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R10 clear", {8'h0, d}, 16'h00);
        chk("R8 irq_edge low", {15'h0, irq_edge}, 16'h0);
        pulse(1'b1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R10 write zero keeps", {8'h0, d}, 16'h01);
        wr(2'd1, 8'h03);

        // R4 R5: falling edges, timer enabled
        timer_en = 1'b1;
        wr(2'd0, 8'h02);
        set_cnt(16'h0000);
        pin_in = 1'b1; hold(5);
        rd_cnt(c); chk("R4 rise ignored", c, 16'd0);
        pulse(1'b0); pulse(1'b0);
        pin_in = 1'b0; hold(5);
        rd_cnt(c); chk("R4 R5 falling count", c, 16'd3);
        timer_en = 1'b0;
        wr(2'd1, 8'h03);

        // R9 overflow
        wr(2'd0, 8'h08);
        set_cnt(16'hFFFE);
        pulse(1'b1);
        rd_cnt(c); chk("R9 to FFFF", c, 16'hFFFF);
        rd(2'd1, d); chk("R9 no ovf at FFFF", {8'h0, d}, 16'h01);
        pulse(1'b1);
        rd_cnt(c); chk("R9 wrap", c, 16'h0000);
        rd(2'd1, d); chk("R9 ovf flag", {8'h0, d}, 16'h03);
        chk("R8 R9 irqs", {14'h0, irq_edge, irq_ovf}, 16'h1);
        wr(2'd1, 8'h02);
        rd(2'd1, d); chk("R10 clear ovf only", {8'h0, d}, 16'h01);
        chk("R9 irq_ovf low", {15'h0, irq_ovf}, 16'h0);

        // R10 set beats clear in the same cycle
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        set_cnt(16'h0100);
        pin_in = 1'b1; hold(2);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R10 set wins", {8'h0, d}, 16'h01);
        rd_cnt(c); chk("R3 count after race", c, 16'h0101);
        pin_in = 1'b0; hold(4);

        // R11 load beats increment in the same cycle
        pin_in = 1'b1; hold(2);
        wr(2'd3, 8'h55);
        hold(2);
        rd_cnt(c); chk("R11 load wins", c, 16'h0155);
        pin_in = 1'b0; hold(4);
        wr(2'd1, 8'h03);

        // R6 R8 gated, active high
        wr(2'd0, 8'h05);
        pin_in = 1'b1; hold(4);
        rd(2'd1, d); chk("R8 gate open no flag", {8'h0, d}, 16'h00);
        set_cnt(16'h0000);
        timer_en = 1'b1;
        hold(192);
        rd_cnt(c); chk("R6 gated 192 clocks", c, 16'd3);
        pin_in = 1'b0;
        hold(200);
        rd_cnt(c); chk("R6 gate closed holds", c, 16'd3);
        rd(2'd1, d); chk("R8 gate close flag", {8'h0, d}, 16'h01);
        chk("R8 gated irq", {15'h0, irq_edge}, 16'h1);

        // R7 gated, timer disabled
        timer_en = 1'b0;
        wr(2'd1, 8'h03);
        pin_in = 1'b1;
        hold(200);
        rd_cnt(c); chk("R7 no time base", c, 16'd3);

        // R6 R8 gated, active low
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h03);
        pin_in = 1'b0; hold(4);
        rd(2'd1, d); chk("R8 low gate open no flag", {8'h0, d}, 16'h00);
        set_cnt(16'h0000);
        timer_en = 1'b1;
        hold(128);
        rd_cnt(c); chk("R6 low gate 128 clocks", c, 16'd2);
        pin_in = 1'b1; hold(4);
        rd(2'd1, d); chk("R8 low gate close flag", {8'h0, d}, 16'h01);
        timer_en = 1'b0;

        done = 1'b1;
        report();
    end

endmodule